// File: doc/BRIEF.md
# Flash Block-Write Buffer Controller

This controller sits between a processor's register bus and a program-flash array. Software stages program words one at a time into a four-slot holding buffer and then commits the whole aligned four-word block to flash in one programming operation. Each slot holds one DATA_W-bit word. The slot is picked by the two low bits of the word address the software has loaded. A staging write to slot 0, 1 or 2 is a short write: the word is copied into the buffer and the go flag drops again on its own after one cycle. A staging write to slot 3 is a long write: that word is loaded and, in the same edge, programming of all four buffered words starts.

A write only takes effect after a two-byte unlock key has reached the key register immediately before the go write. The same control write must also enable writing, select program memory and leave the erase bit clear. A fixed write-protection field marks a region at the top of memory as read-only. A write aimed at that region is refused and raises an error flag. While the block is being programmed, the controller stalls the processor for a parameterised number of clock cycles, and for longer if the flash array still reports busy. When programming completes, the buffer returns to all ones.

Top module: `pgm_blk_writer`

## Requirements
- R1: The buffer holds four DATA_W-bit words. The slot is selected by address bits [1:0]. The staged word is {data-high register bits [DATA_W-9:0], data-low register}. Slot k appears on flash_data[k*DATA_W +: DATA_W].
- R2: An accepted go write whose address bits [1:0] are not 3 stores the word into its slot without pulsing flash_prog. The go bit (control bit 0) reads 1 for exactly one cycle after the write and 0 after that.
- R3: An accepted go write with address bits [1:0] equal to 3 stores the word into slot 3. In the cycle after the write, flash_prog is high for exactly one cycle, flash_addr equals address bits [ADDR_W-1:2], and flash_data carries all four staged words.
- R4: Register selects are 0 address-low, 1 address-high, 2 data-low, 3 data-high, 4 control and 5 key. A go write is accepted only if the two preceding bus writes were 0x55 and then 0xAA to the key register. A 0x55 written to the key register always restarts the sequence, and any other bus write cancels it. A go write that is not accepted leaves the go bit at 0 and the buffer unchanged.
- R5: The same control write must carry enable (bit 1) = 1, program-memory (bit 2) = 1 and erase (bit 3) = 0. Otherwise the go write is ignored, as in R4.
- R6: All four slots read all ones after reset and immediately after every long write completes.
- R7: prot_cfg selects the protected range. Code 0 protects all addresses. Code 1 protects addresses at or above half of memory. Code 2 protects addresses at or above three quarters of memory. Code 3 protects nothing. A go write to a protected address, short or long, changes no slot and starts no programming.
- R8: cpu_stall rises in the same cycle as the flash_prog pulse. It stays high for PROG_CYCLES cycles, and beyond that until flash_busy is low.
- R9: The busy bit (control bit 4) is high while programming is under way. It clears together with the go bit on the edge where programming completes.
- R10: The error bit (control bit 5) is set by a refused protected write and cleared by the next accepted write.
- R11: Reads return the address and data registers, zero-extended and truncated to their implemented widths. The control register reads {2'b0, error, busy, erase, program-memory, enable, go}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 3 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| prot_cfg | input | 2 | Write-protection code |
| flash_busy | input | 1 | Flash array still programming |
| flash_prog | output | 1 | One-cycle start-programming strobe |
| flash_addr | output | ADDR_W-2 | Block address being programmed |
| flash_data | output | 4*DATA_W | The four buffered words |
| cpu_stall | output | 1 | Processor stall during programming |

## Verification
The bench goes after five areas: key sequences that are broken or out of order, missing enable bits, the exact edges of each protected range, slot-3 writes that start programming, and a flash array that stays busy past the nominal time. If the unlock check were too loose, a stray go write would change a slot, and the bench would see the changed slot on flash_data. If the range comparisons were off by one, addresses right at the half and three-quarter limits would be accepted or refused wrongly, and the error bit would show it. If the stall counter or the busy handshake were wrong, the bench would count the wrong number of stall cycles. If the buffer were not reset after programming, flash_data would keep the old words instead of going back to all ones.

// File: rtl/pbw_pkg.sv
package pbw_pkg;
   localparam logic [2:0] SEL_ADRL = 3'd0;
   localparam logic [2:0] SEL_ADRH = 3'd1;
   localparam logic [2:0] SEL_DATL = 3'd2;
   localparam logic [2:0] SEL_DATH = 3'd3;
   localparam logic [2:0] SEL_CTRL = 3'd4;
   localparam logic [2:0] SEL_KEY  = 3'd5;

   localparam logic [7:0] KEY_FIRST  = 8'h55;
   localparam logic [7:0] KEY_SECOND = 8'hAA;

   localparam int CB_GO    = 0;
   localparam int CB_WEN   = 1;
   localparam int CB_PMEM  = 2;
   localparam int CB_ERASE = 3;

   typedef enum logic [1:0] {KS_IDLE, KS_HALF, KS_ARMED} key_st_e;
   typedef enum logic [1:0] {SQ_IDLE, SQ_SHORT, SQ_LONG} seq_st_e;
endpackage

// File: rtl/pbw_unlock.sv
module pbw_unlock
   import pbw_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [2:0] wr_sel,
   input  logic [7:0] wr_data,
   output logic       armed
);
   key_st_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (wr_en) begin
         if (wr_sel == SEL_KEY && wr_data == KEY_FIRST)
            st_d = KS_HALF;
         else if (wr_sel == SEL_KEY && wr_data == KEY_SECOND && st_q == KS_HALF)
            st_d = KS_ARMED;
         else
            st_d = KS_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= KS_IDLE;
      else        st_q <= st_d;
   end

   assign armed = (st_q == KS_ARMED);
endmodule

// File: rtl/pbw_guard.sv
module pbw_guard #(
   parameter int ADDR_W = 10
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        code,
   output logic              hit
);
   localparam logic [ADDR_W:0] LIM_ALL  = '0;
   localparam logic [ADDR_W:0] LIM_HALF = {2'b01, {(ADDR_W-1){1'b0}}};
   localparam logic [ADDR_W:0] LIM_Q3   = {3'b011, {(ADDR_W-2){1'b0}}};

   logic [ADDR_W:0] limit;

   always_comb begin
      unique case (code)
         2'b00:   limit = LIM_ALL;
         2'b01:   limit = LIM_HALF;
         2'b10:   limit = LIM_Q3;
         default: limit = LIM_ALL;
      endcase
   end

   assign hit = (code != 2'b11) && ({1'b0, addr} >= limit);
endmodule

// File: rtl/pbw_buffer.sv
module pbw_buffer #(
   parameter int DATA_W = 14,
   parameter int SLOTS  = 4,
   localparam int SLOT_W = $clog2(SLOTS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ld,
   input  logic [SLOT_W-1:0]       ld_slot,
   input  logic [DATA_W-1:0]       ld_word,
   input  logic                    clr,
   output logic [SLOTS*DATA_W-1:0] words
);
   if ((1 << SLOT_W) != SLOTS) begin : g_bad_slots
      $error("pbw_buffer: SLOTS must be a power of two");
   end

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '1;
         else if (clr)
            word_q <= '1;
         else if (ld && ld_slot == SLOT_W'(g))
            word_q <= ld_word;
      end
      assign words[g*DATA_W +: DATA_W] = word_q;
   end
endmodule

// File: rtl/pbw_seq.sv
module pbw_seq
   import pbw_pkg::*;
#(
   parameter int PROG_CYCLES = 250000,
   localparam int CNT_W = $clog2(PROG_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_short,
   input  logic start_long,
   input  logic flash_busy,
   output logic go,
   output logic busy,
   output logic prog,
   output logic done
);
   if (PROG_CYCLES < 1) begin : g_bad_cycles
      $error("pbw_seq: PROG_CYCLES must be at least 1");
   end

   seq_st_e          st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             prog_q;

   assign done = (st_q == SQ_LONG) && (cnt_q == '0) && !flash_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SQ_IDLE;
         cnt_q  <= '0;
         prog_q <= 1'b0;
      end else begin
         prog_q <= 1'b0;
         unique case (st_q)
            SQ_IDLE: begin
               if (start_long) begin
                  st_q   <= SQ_LONG;
                  cnt_q  <= CNT_W'(PROG_CYCLES - 1);
                  prog_q <= 1'b1;
               end else if (start_short) begin
                  st_q <= SQ_SHORT;
               end
            end
            SQ_SHORT: st_q <= SQ_IDLE;
            SQ_LONG: begin
               if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
               else if (done)     st_q  <= SQ_IDLE;
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign go   = (st_q != SQ_IDLE);
   assign busy = (st_q == SQ_LONG);
   assign prog = prog_q;
endmodule

// File: rtl/pgm_blk_writer.sv
module pgm_blk_writer
   import pbw_pkg::*;
#(
   parameter int ADDR_W      = 10,
   parameter int DATA_W      = 14,
   parameter int PROG_CYCLES = 250000,
   localparam int SLOTS      = 4,
   localparam int BLK_W      = ADDR_W - 2,
   localparam int AH_W       = ADDR_W - 8,
   localparam int DH_W       = DATA_W - 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_we,
   input  logic [2:0]              bus_sel,
   input  logic [7:0]              bus_wdata,
   output logic [7:0]              bus_rdata,
   input  logic [1:0]              prot_cfg,
   input  logic                    flash_busy,
   output logic                    flash_prog,
   output logic [BLK_W-1:0]        flash_addr,
   output logic [SLOTS*DATA_W-1:0] flash_data,
   output logic                    cpu_stall
);
   if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
      $error("pgm_blk_writer: ADDR_W must be within 9..16");
   end
   if (DATA_W < 9 || DATA_W > 16) begin : g_bad_data
      $error("pgm_blk_writer: DATA_W must be within 9..16");
   end

   logic [7:0]       adr_lo, dat_lo;
   logic [AH_W-1:0]  adr_hi;
   logic [DH_W-1:0]  dat_hi;
   logic             c_wen, c_pmem, c_erase, err_q;
   logic [BLK_W-1:0] blk_q;

   logic              armed, hit, seq_go, seq_busy, seq_done;
   logic [ADDR_W-1:0] full_addr;
   logic              wr_ctl, attempt, accept, reject, is_long;

   assign full_addr = {adr_hi, adr_lo};
   assign wr_ctl    = bus_we && (bus_sel == SEL_CTRL);
   assign attempt   = wr_ctl && bus_wdata[CB_GO] && armed && !seq_go
                      && bus_wdata[CB_WEN] && bus_wdata[CB_PMEM]
                      && !bus_wdata[CB_ERASE];
   assign accept    = attempt && !hit;
   assign reject    = attempt && hit;
   assign is_long   = (full_addr[1:0] == 2'b11);

   pbw_unlock u_unlock (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_we),
      .wr_sel  (bus_sel),
      .wr_data (bus_wdata),
      .armed   (armed)
   );

   pbw_guard #(.ADDR_W(ADDR_W)) u_guard (
      .addr (full_addr),
      .code (prot_cfg),
      .hit  (hit)
   );

   pbw_buffer #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld      (accept),
      .ld_slot (full_addr[1:0]),
      .ld_word ({dat_hi, dat_lo}),
      .clr     (seq_done),
      .words   (flash_data)
   );

   pbw_seq #(.PROG_CYCLES(PROG_CYCLES)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_short (accept && !is_long),
      .start_long  (accept && is_long),
      .flash_busy  (flash_busy),
      .go          (seq_go),
      .busy        (seq_busy),
      .prog        (flash_prog),
      .done        (seq_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adr_lo  <= '0;
         adr_hi  <= '0;
         dat_lo  <= '0;
         dat_hi  <= '0;
         c_wen   <= 1'b0;
         c_pmem  <= 1'b0;
         c_erase <= 1'b0;
         err_q   <= 1'b0;
         blk_q   <= '0;
      end else begin
         if (bus_we) begin
            unique case (bus_sel)
               SEL_ADRL: adr_lo <= bus_wdata;
               SEL_ADRH: adr_hi <= bus_wdata[AH_W-1:0];
               SEL_DATL: dat_lo <= bus_wdata;
               SEL_DATH: dat_hi <= bus_wdata[DH_W-1:0];
               SEL_CTRL: begin
                  c_wen   <= bus_wdata[CB_WEN];
                  c_pmem  <= bus_wdata[CB_PMEM];
                  c_erase <= bus_wdata[CB_ERASE];
               end
               default: ;
            endcase
         end
         if (reject)      err_q <= 1'b1;
         else if (accept) err_q <= 1'b0;
         if (accept && is_long) blk_q <= full_addr[ADDR_W-1:2];
      end
   end

   always_comb begin
      unique case (bus_sel)
         SEL_ADRL: bus_rdata = adr_lo;
         SEL_ADRH: bus_rdata = 8'(adr_hi);
         SEL_DATL: bus_rdata = dat_lo;
         SEL_DATH: bus_rdata = 8'(dat_hi);
         SEL_CTRL: bus_rdata = {2'b00, err_q, seq_busy, c_erase, c_pmem, c_wen, seq_go};
         default:  bus_rdata = 8'h00;
      endcase
   end

   assign flash_addr = blk_q;
   assign cpu_stall  = seq_busy;

   logic blk_hit;
   pbw_guard #(.ADDR_W(ADDR_W)) u_blk_guard (
      .addr ({blk_q, 2'b00}),
      .code (prot_cfg),
      .hit  (blk_hit)
   );

   AST_PROG_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      flash_prog |-> $past(armed)); // R4
   AST_PROG_UNPROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
      flash_prog |-> !blk_hit); // R7
   AST_BUF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(seq_busy) |-> (flash_data == '1)); // R6
   AST_STALL_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_stall) |-> flash_prog); // R8
   AST_SHORT_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_go && !seq_busy) |-> !flash_prog); // R2
endmodule

// File: tb/pgm_blk_writer_tb.sv
module pgm_blk_writer_tb;
   localparam int AW = 10;
   localparam int DW = 14;
   localparam int PC = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_we = 1'b0;
   logic [2:0]    bus_sel = '0;
   logic [7:0]    bus_wdata = '0;
   logic [7:0]    bus_rdata;
   logic [1:0]    prot_cfg = 2'b11;
   logic          flash_busy = 1'b0;
   logic          flash_prog;
   logic [AW-3:0] flash_addr;
   logic [4*DW-1:0] flash_data;
   logic          cpu_stall;

   int total = 0;
   int bad = 0;
   logic [DW-1:0] eb [4];

   always #4ns clk = ~clk;

   pgm_blk_writer #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PC)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .prot_cfg(prot_cfg),
      .flash_busy(flash_busy), .flash_prog(flash_prog), .flash_addr(flash_addr),
      .flash_data(flash_data), .cpu_stall(cpu_stall)
   );

   initial begin
      #1600us;
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [4*DW-1:0] packed_exp();
      return {eb[3], eb[2], eb[1], eb[0]};
   endfunction

   task automatic bus_wr(input logic [2:0] s, input logic [7:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_sel = s; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] s, output logic [7:0] v);
      bus_sel = s;
      #1ns;
      v = bus_rdata;
   endtask

   task automatic stage(input logic [AW-1:0] a, input logic [DW-1:0] w);
      bus_wr(3'd0, a[7:0]);
      bus_wr(3'd1, {6'b0, a[9:8]});
      bus_wr(3'd2, w[7:0]);
      bus_wr(3'd3, {2'b0, w[13:8]});
   endtask

   // R1 R2 R3 R6 R8 R9: accepted write, model updated and checked
   task automatic good_write(input logic [AW-1:0] a, input logic [DW-1:0] w, input int hold);
      logic [7:0] v;
      int st_n, pr_n;
      stage(a, w);
      bus_wr(3'd5, 8'h55);
      bus_wr(3'd5, 8'hAA);
      if (hold > 0) flash_busy = 1'b1;
      bus_wr(3'd4, 8'h07);
      if (a[1:0] != 2'b11) begin
         eb[a[1:0]] = w;
         rd_reg(3'd4, v);
         check("R2 go high one cycle", 64'(v[0]), 64'd1);
         check("R2 no strobe", 64'(flash_prog), 64'd0);
         check("R1 slot content", 64'(flash_data), 64'(packed_exp()));
         @(negedge clk);
         rd_reg(3'd4, v);
         check("R2 go cleared", 64'(v[0]), 64'd0);
      end else begin
         eb[3] = w;
         check("R3 block address", 64'(flash_addr), 64'(a >> 2));
         check("R3 block data", 64'(flash_data), 64'(packed_exp()));
         st_n = 0; pr_n = 0;
         for (int i = 0; i < 40; i++) begin
            if (cpu_stall) st_n++;
            if (flash_prog) pr_n++;
            if (i == 3) begin
               rd_reg(3'd4, v);
               check("R9 busy during program", 64'(v[4]), 64'd1);
            end
            if (i == hold) flash_busy = 1'b0;
            @(negedge clk);
         end
         check("R3 strobe width", 64'(pr_n), 64'd1);
         check("R8 stall cycles", 64'(st_n), 64'((hold + 1 > PC) ? hold + 1 : PC));
         for (int k = 0; k < 4; k++) eb[k] = '1;
         check("R6 buffer reset after program", 64'(flash_data), 64'(packed_exp()));
         rd_reg(3'd4, v);
         check("R9 busy and go cleared", 64'(v[4:0]), 64'h06);
      end
   endtask

   task automatic expect_ignored(input string tag);
      logic [7:0] v;
      rd_reg(3'd4, v);
      check({tag, " go stays low"}, 64'(v[0]), 64'd0);
      @(negedge clk);
      check({tag, " buffer unchanged"}, 64'(flash_data), 64'(packed_exp()));
      check({tag, " no strobe"}, 64'(flash_prog), 64'd0);
   endtask

   initial begin
      logic [7:0] v;
      for (int k = 0; k < 4; k++) eb[k] = '1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      check("R6 reset buffer", 64'(flash_data), 64'(packed_exp()));
      rd_reg(3'd4, v);
      check("R9 reset control", 64'(v), 64'd0);
      check("R8 reset stall", 64'(cpu_stall), 64'd0);

      // R11 readback with truncation
      bus_wr(3'd0, 8'hA5);
      bus_wr(3'd1, 8'hFF);
      bus_wr(3'd2, 8'h5A);
      bus_wr(3'd3, 8'hFF);
      rd_reg(3'd0, v); check("R11 addr low", 64'(v), 64'hA5);
      rd_reg(3'd1, v); check("R11 addr high", 64'(v), 64'h03);
      rd_reg(3'd2, v); check("R11 data low", 64'(v), 64'h5A);
      rd_reg(3'd3, v); check("R11 data high", 64'(v), 64'h3F);
      rd_reg(3'd5, v); check("R11 key reads zero", 64'(v), 64'h00);

      // R1 R2 R3: blocks, in-order and out-of-order slots
      for (int b = 0; b < 4; b++) begin
         int blk;
         blk = (b == 0) ? 0 : (b == 1) ? 1 : (b == 2) ? 100 : 255;
         for (int k = 0; k < 4; k++) begin
            int slot;
            slot = (b == 2) ? ((k == 0) ? 2 : (k == 1) ? 0 : (k == 2) ? 1 : 3) : k;
            if (b == 3 && slot != 3) continue;
            good_write(AW'(blk * 4 + slot), DW'(blk * 37 + slot * 1111 + 5), 0);
         end
      end

      // R4 unlock violations
      stage(10'h004, 14'h1234);
      bus_wr(3'd4, 8'h07);
      expect_ignored("R4 no key");
      bus_wr(3'd5, 8'h55); bus_wr(3'd2, 8'h11); bus_wr(3'd5, 8'hAA); bus_wr(3'd4, 8'h07);
      expect_ignored("R4 write between keys");
      bus_wr(3'd5, 8'hAA); bus_wr(3'd5, 8'h55); bus_wr(3'd4, 8'h07);
      expect_ignored("R4 reversed keys");
      bus_wr(3'd5, 8'h55); bus_wr(3'd5, 8'hAA); bus_wr(3'd0, 8'h04); bus_wr(3'd4, 8'h07);
      expect_ignored("R4 write after keys");
      // R5 enable bits
      bus_wr(3'd5, 8'h55); bus_wr(3'd5, 8'hAA); bus_wr(3'd4, 8'h05);
      expect_ignored("R5 enable clear");
      bus_wr(3'd5, 8'h55); bus_wr(3'd5, 8'hAA); bus_wr(3'd4, 8'h03);
      expect_ignored("R5 program-memory clear");
      bus_wr(3'd5, 8'h55); bus_wr(3'd5, 8'hAA); bus_wr(3'd4, 8'h0F);
      expect_ignored("R5 erase set");
      // R4 repeated first key restarts
      bus_wr(3'd5, 8'h55); bus_wr(3'd5, 8'h55); bus_wr(3'd5, 8'hAA); bus_wr(3'd4, 8'h07);
      eb[0] = 14'h1211;
      rd_reg(3'd4, v);
      check("R4 repeated key accepted", 64'(v[0]), 64'd1);
      @(negedge clk);
      check("R4 repeated key data", 64'(flash_data), 64'(packed_exp()));

      // R7 R10 protection sweep
      for (int c = 0; c < 4; c++) begin
         prot_cfg = 2'(c);
         for (int j = 0; j < 6; j++) begin
            int a;
            logic p;
            logic [DW-1:0] w;
            a = (j == 0) ? 0 : (j == 1) ? 508 : (j == 2) ? 512 :
                (j == 3) ? 764 : (j == 4) ? 768 : 1020;
            p = (c == 0) ? 1'b1 : (c == 1) ? (a >= 512) : (c == 2) ? (a >= 768) : 1'b0;
            w = DW'(a * 3 + c + 7);
            stage(AW'(a), w);
            bus_wr(3'd5, 8'h55); bus_wr(3'd5, 8'hAA); bus_wr(3'd4, 8'h07);
            if (!p) eb[0] = w;
            rd_reg(3'd4, v);
            check("R10 error flag", 64'(v[5]), 64'(p));
            check("R7 go on protection", 64'(v[0]), 64'(!p));
            @(negedge clk);
            check("R7 slot after protection", 64'(flash_data), 64'(packed_exp()));
         end
      end
      // R7 protected long write
      prot_cfg = 2'b01;
      stage(10'h3FF, 14'h0ABC);
      bus_wr(3'd5, 8'h55); bus_wr(3'd5, 8'hAA); bus_wr(3'd4, 8'h07);
      rd_reg(3'd4, v);
      check("R10 long rejected error", 64'(v[5]), 64'd1);
      check("R7 long rejected strobe", 64'(flash_prog), 64'd0);
      check("R7 long rejected stall", 64'(cpu_stall), 64'd0);
      @(negedge clk);
      check("R7 long rejected buffer", 64'(flash_data), 64'(packed_exp()));
      prot_cfg = 2'b11;

      // R8 R9 flash busy extends programming
      good_write(10'h0F0, 14'h2222, 0);
      rd_reg(3'd4, v);
      check("R10 error cleared by accepted write", 64'(v[5]), 64'd0);
      good_write(10'h0F3, 14'h3333, 10);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule